// File: doc/BRIEF.md
# Radix-4 Recoded Carry-Save Fraction Multiplier

This block multiplies two unsigned fixed-point fraction magnitudes and returns a product of twice the operand width. The multiplier operand is consumed two bits per clock. Each two-bit group, together with a carry from the group below, is rewritten as one digit from the set {-1, 0, +1, +2}. That digit selects a partial product of zero, the multiplicand, twice the multiplicand or its negation.

Partial products go into a redundant accumulator. The accumulator holds a two-bit sum and one stored carry bit per radix-4 digit, so no carry travels more than one digit in any step. After each step the accumulator moves down by one digit, and the retired low digit is kept in a lower register. After the last step, a single wide addition turns the redundant value into ordinary binary and removes the constant offset that keeps every partial sum non-negative.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. It then waits for the one-cycle `done` pulse and reads `product`, which holds its value until the next `done`.

Top module: `r4mul_top`

## Requirements
- R1: `product` equals `multiplicand` × `multiplier` exactly, both read as unsigned WIDTH-bit integers, over the full 2·WIDTH-bit result.
- R2: `done` rises on the (NSTEP+1)-th rising edge after the edge that accepts `start`, where NSTEP = ceil(WIDTH/2)+1. With WIDTH = 45 this is the 25th edge.
- R3: `done` is high for exactly one clock cycle per accepted operation.
- R4: `product` keeps its value in every cycle in which `done` is low.
- R5: `start` is accepted only while idle, and the cycle in which `done` is high counts as idle. A `start` seen during an operation has no effect on its result or its timing, and it starts no second operation.
- R6: Recoding adds the incoming carry to the raw pair value. Sums 0, 1 and 2 give digits 0, +1 and +2 with carry 0. A sum of 3 gives digit -1 with carry 1, and a sum of 4 gives digit 0 with carry 1. One extra final step uses the leftover carry as its digit, so that digit is 0 or +1.
- R7: A digit of -1 adds the bitwise inverse of the multiplicand plus a +1 held in the carry vector at that digit position. Multipliers whose pairs read 3 still give exact products.
- R8: When WIDTH is odd, the multiplier is zero-extended by one bit on top before it is split into pairs. A multiplier with only its top bit set gives an exact product.
- R9: The accumulator stores one carry bit per two sum bits, and no carry leaves its top digit during an operation. Products of all-ones operands are exact.
- R10: `rst_n` low clears the block asynchronously, and its release is synchronized over two clock edges. During and after reset, `done` is 0 and `product` is 0.
- R11: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| multiplicand | input | WIDTH | Multiplicand fraction magnitude, captured with start |
| multiplier | input | WIDTH | Multiplier fraction magnitude, captured with start |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2*WIDTH | Double-length product, held between pulses |

## Verification
Several properties are checked on every cycle:
- the single-cycle width of `done` and its exact distance from the accepting edge;
- the stability of `product` outside `done`;
- the absence of a carry out of the accumulator's top digit while scanning;
- the range of the digit in the final step;
- that the assimilated value never exceeds 2·WIDTH bits.

Only the bench scenarios can show that the arithmetic is right: recoding chains with long carry runs, pairs that produce -1, the zero-extended top bit, zero operands, and random operands compared against an exact product. The same holds for a mid-operation `start` being ignored, and for the reset values.

// File: rtl/r4mul_pkg.sv
package r4mul_pkg;

  // Recoded radix-4 digit; the encoding is local to the datapath
  typedef enum logic [1:0] {
    DG_ZERO = 2'd0,
    DG_ONE  = 2'd1,
    DG_TWO  = 2'd2,
    DG_NEG  = 2'd3
  } digit_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_MERGE = 2'd2
  } mstate_e;

endpackage

// File: rtl/r4mul_recode.sv
module r4mul_recode
  import r4mul_pkg::*;
(
  input  logic [1:0] raw,
  input  logic       carry_in,
  output digit_e     dig,
  output logic       carry_out
);

  logic [2:0] total;

  assign total = {1'b0, raw} + {2'b00, carry_in};

  always_comb begin
    dig       = DG_ZERO;
    carry_out = 1'b0;
    case (total)
      3'd0: dig = DG_ZERO;
      3'd1: dig = DG_ONE;
      3'd2: dig = DG_TWO;
      3'd3: begin
        dig       = DG_NEG;
        carry_out = 1'b1;
      end
      default: begin
        dig       = DG_ZERO;
        carry_out = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/r4mul_ppsel.sv
module r4mul_ppsel
  import r4mul_pkg::*;
#(
  parameter int WIDTH = 45,
  parameter int OUT_W = 48
) (
  input  logic [WIDTH-1:0] mcand,
  input  digit_e           dig,
  output logic [OUT_W-1:0] pp,
  output logic             neg_inj
);

  localparam int ENC_W = WIDTH + 2;

  // Every encoding carries an offset of 2^(WIDTH+1) so it is never negative
  logic [ENC_W-1:0] enc;

  always_comb begin
    case (dig)
      DG_ZERO: enc = {2'b10, {WIDTH{1'b0}}};
      DG_ONE:  enc = {2'b10, mcand};
      DG_TWO:  enc = {1'b1, mcand, 1'b0};
      default: enc = {2'b01, ~mcand};
    endcase
  end

  assign pp      = OUT_W'(enc);
  assign neg_inj = (dig == DG_NEG);

endmodule

// File: rtl/r4mul_csa_row.sv
module r4mul_csa_row #(
  parameter int NDIG = 24
) (
  input  logic [2*NDIG-1:0] sum_in,
  input  logic [NDIG-1:0]   carry_in,
  input  logic [2*NDIG-1:0] addend,
  output logic [2*NDIG-1:0] sum_out,
  output logic [NDIG-1:0]   carry_out
);

  // Each digit adds in isolation: result 0..7 splits into two sum bits and one carry
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [2:0] dsum;
    assign dsum = {1'b0, sum_in[2*i +: 2]} + {1'b0, addend[2*i +: 2]}
                + {2'b00, carry_in[i]};
    assign sum_out[2*i +: 2] = dsum[1:0];
    assign carry_out[i]      = dsum[2];
  end

endmodule

// File: rtl/r4mul_top.sv
module r4mul_top
  import r4mul_pkg::*;
#(
  parameter int WIDTH = 45
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     multiplicand,
  input  logic [WIDTH-1:0]     multiplier,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);

  localparam int NPAIR  = (WIDTH + 1) / 2;
  localparam int QW     = 2 * NPAIR;
  localparam int NSTEP  = NPAIR + 1;
  localparam int ACC_D  = (WIDTH + 4) / 2;
  localparam int ACC_W  = 2 * ACC_D;
  localparam int LO_W   = 2 * NSTEP;
  localparam int FULL_W = ACC_W + LO_W;
  localparam int PW     = 2 * WIDTH;
  localparam int CNT_W  = $clog2(NSTEP + 1);

  // Sum of the per-step offsets added by the partial-product encoder
  function automatic logic [FULL_W-1:0] offset_total();
    logic [FULL_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NSTEP; k++) begin
      acc = acc + ({{(FULL_W-1){1'b0}}, 1'b1} << (WIDTH + 1 + 2*k));
    end
    return acc;
  endfunction

  localparam logic [FULL_W-1:0] OFFSET = offset_total();

  // Reset: asserted asynchronously, released on the second edge
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // Registers and their next values
  mstate_e           state_q, state_d;
  logic [CNT_W-1:0]  step_q,  step_d;
  logic [WIDTH-1:0]  mcand_q, mcand_d;
  logic [QW-1:0]     mplr_q,  mplr_d;
  logic              rc_q,    rc_d;
  logic [ACC_W-1:0]  acc_s_q, acc_s_d;
  logic [ACC_D-1:0]  acc_c_q, acc_c_d;
  logic [LO_W-1:0]   lo_s_q,  lo_s_d;
  logic [NSTEP-1:0]  lo_c_q,  lo_c_d;
  logic [PW-1:0]     prod_q;
  logic              done_q;

  // Control decodes and clock enables
  logic idle, scanning, merging, accept, last_step;
  logic load_en, step_en, out_en;

  assign idle      = (state_q == ST_IDLE);
  assign scanning  = (state_q == ST_SCAN);
  assign merging   = (state_q == ST_MERGE);
  assign accept    = idle && start;
  assign last_step = scanning && (step_q == CNT_W'(NSTEP - 1));
  assign load_en   = accept;
  assign step_en   = scanning;
  assign out_en    = merging;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SCAN;
          step_d  = '0;
        end
      end
      ST_SCAN: begin
        step_d = step_q + 1'b1;
        if (last_step) state_d = ST_MERGE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // One recode / select / redundant-add step per cycle
  digit_e            dig;
  logic              rc_next;
  logic [ACC_W-1:0]  pp;
  logic              neg_inj;
  logic [ACC_W-1:0]  row_sum;
  logic [ACC_D-1:0]  row_cout;

  r4mul_recode u_recode (
    .raw       (mplr_q[1:0]),
    .carry_in  (rc_q),
    .dig       (dig),
    .carry_out (rc_next)
  );

  r4mul_ppsel #(.WIDTH(WIDTH), .OUT_W(ACC_W)) u_ppsel (
    .mcand   (mcand_q),
    .dig     (dig),
    .pp      (pp),
    .neg_inj (neg_inj)
  );

  r4mul_csa_row #(.NDIG(ACC_D)) u_row (
    .sum_in    (acc_s_q),
    .carry_in  (acc_c_q),
    .addend    (pp),
    .sum_out   (row_sum),
    .carry_out (row_cout)
  );

  always_comb begin
    mcand_d = mcand_q;
    mplr_d  = mplr_q;
    rc_d    = rc_q;
    acc_s_d = acc_s_q;
    acc_c_d = acc_c_q;
    lo_s_d  = lo_s_q;
    lo_c_d  = lo_c_q;
    if (load_en) begin
      mcand_d = multiplicand;
      mplr_d  = QW'(multiplier);
      rc_d    = 1'b0;
      acc_s_d = '0;
      acc_c_d = '0;
      lo_s_d  = '0;
      lo_c_d  = '0;
    end else if (step_en) begin
      mplr_d  = mplr_q >> 2;
      rc_d    = rc_next;
      acc_s_d = {2'b00, row_sum[ACC_W-1:2]};
      acc_c_d = row_cout;
      lo_s_d  = {row_sum[1:0], lo_s_q[LO_W-1:2]};
      lo_c_d  = {neg_inj, lo_c_q[NSTEP-1:1]};
    end
  end

  // Final carry assimilation: one carry bit sits at the base of each digit
  logic [FULL_W-1:0] sum_vec;
  logic [FULL_W-1:0] carry_vec;
  logic [FULL_W-1:0] full;
  logic [FULL_W-PW-1:0] full_hi;
  logic              top_carry;
  logic [1:0]        dig_bits;

  assign sum_vec = {acc_s_q, lo_s_q};

  always_comb begin
    carry_vec = '0;
    for (int d = 0; d < NSTEP; d++) carry_vec[2*d] = lo_c_q[d];
    for (int d = 0; d < ACC_D; d++) carry_vec[2*(NSTEP+d)] = acc_c_q[d];
  end

  assign full      = sum_vec + carry_vec - OFFSET;
  assign full_hi   = full[FULL_W-1:PW];
  assign top_carry = row_cout[ACC_D-1];
  assign dig_bits  = dig;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      rc_q    <= 1'b0;
      acc_s_q <= '0;
      acc_c_q <= '0;
      lo_s_q  <= '0;
      lo_c_q  <= '0;
      prod_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= out_en;
      if (load_en || step_en) begin
        mcand_q <= mcand_d;
        mplr_q  <= mplr_d;
        rc_q    <= rc_d;
        acc_s_q <= acc_s_d;
        acc_c_q <= acc_c_d;
        lo_s_q  <= lo_s_d;
        lo_c_q  <= lo_c_d;
      end
      if (out_en) prod_q <= full[PW-1:0];
    end
  end

  assign done    = done_q;
  assign product = prod_q;

endmodule

// File: rtl/r4mul_chk.sv
module r4mul_chk #(
  parameter int WIDTH = 45
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scanning,
  input logic               merging,
  input logic               idle,
  input logic               start,
  input logic               last_step,
  input logic [1:0]         digit,
  input logic               top_carry,
  input logic               done,
  input logic [2*WIDTH-1:0] product,
  input logic [2*(((WIDTH+1)/2)+1+((WIDTH+4)/2))-2*WIDTH-1:0] full_hi
);

  localparam int NSTEP = (WIDTH + 1) / 2 + 1;
  localparam int LAT   = NSTEP + 1;
  localparam int LAT_W = $clog2(LAT + 1) + 1;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lat_q <= '0;
    else if (idle && start) lat_q <= '0;
    else if (!idle)         lat_q <= lat_q + 1'b1;
  end

  AST_DONE_SINGLE:      assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_PRODUCT_HELD:     assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(product)); // R4
  AST_DONE_LATENCY:     assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat_q == LAT_W'(LAT))); // R2
  AST_ACC_NO_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n) scanning |-> !top_carry); // R9
  AST_LAST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) last_step |-> (digit <= 2'd1)); // R6
  AST_PRODUCT_FITS:     assert property (@(posedge clk) disable iff (!rst_n) merging |-> (full_hi == '0)); // R1

endmodule

bind r4mul_top r4mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scanning  (scanning),
  .merging   (merging),
  .idle      (idle),
  .start     (start),
  .last_step (last_step),
  .digit     (dig_bits),
  .top_carry (top_carry),
  .done      (done),
  .product   (product),
  .full_hi   (full_hi)
);

// File: tb/tb_r4mul_top.sv
`timescale 1ns/1ps
module tb_r4mul_top;

  localparam int W     = 45;
  localparam int NSTEP = (W + 1) / 2 + 1;
  localparam int LAT   = NSTEP + 1;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   mcand;
  logic [W-1:0]   mplr;
  logic           done;
  logic [2*W-1:0] product;

  int nvec;
  int nfail;
  logic [63:0] rng;

  r4mul_top #(.WIDTH(W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplr),
    .done         (done),
    .product      (product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] wa;
    logic [2*W-1:0] wb;
    wa = {{W{1'b0}}, a};
    wb = {{W{1'b0}}, b};
    return wa * wb;
  endfunction

  function automatic logic [W-1:0] next_rand();
    logic [63:0] x;
    logic [63:0] y;
    x = rng;
    x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
    y = x;
    y = y ^ (y << 13); y = y ^ (y >> 7); y = y ^ (y << 17);
    rng = y;
    return W'({x[31:0], y[31:0]});
  endfunction

  function automatic logic [W-1:0] stripes(input int period, input int phase);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (((i + phase) / period) % 2) == 0;
    return v;
  endfunction

  task automatic check_vec(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts at a negedge; returns at the negedge one cycle after done
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int cyc;
    mcand = a; mplr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < LAT + 10) begin
      @(negedge clk);
      cyc++;
    end
    check_int("R2 latency", cyc, LAT);
    check_vec(req, product, exp_prod(a, b));
    @(negedge clk);
    check_int("R3 done width", int'(done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; mcand = '0; mplr = '0;
    repeat (3) @(negedge clk);
    check_int("R10 done in reset", int'(done), 0);
    check_vec("R10 product in reset", product, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_int("R10 done after reset", int'(done), 0);
    check_vec("R10 product after reset", product, '0);
  endtask

  task automatic t_zero();
    run_mul('0, next_rand(), "R11 zero multiplicand");
    run_mul(next_rand(), '0, "R11 zero multiplier");
  endtask

  task automatic t_recode();
    run_mul('1, '1, "R7 all pairs read 3");
    run_mul(W'(1), '1, "R6 carry chain to final digit");
    run_mul(next_rand(), stripes(1, 1), "R6 digits of +2");
    run_mul(next_rand(), stripes(1, 0), "R6 digits of +1");
    run_mul('1, stripes(2, 0), "R7 alternating 3 and 0 pairs");
    run_mul(next_rand(), stripes(2, 2), "R7 alternating 0 and 3 pairs");
    run_mul('1, '1, "R9 widest accumulator values");
  endtask

  task automatic t_topbit();
    run_mul('1, W'(1) << (W - 1), "R8 top multiplier bit alone");
    run_mul(next_rand(), W'(3) << (W - 2), "R8 top two multiplier bits");
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) run_mul(next_rand(), next_rand(), "R1 random operands");
  endtask

  task automatic t_ignore_start();
    logic [W-1:0] a;
    logic [W-1:0] b;
    int cyc;
    int extra;
    a = next_rand(); b = next_rand();
    mcand = a; mplr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < LAT + 10) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) begin
        mcand = next_rand(); mplr = next_rand(); start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check_int("R5 latency with extra start", cyc, LAT);
    check_vec("R5 result with extra start", product, exp_prod(a, b));
    extra = 0;
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check_int("R5 no second operation", extra, 0);
  endtask

  task automatic t_hold();
    logic [2*W-1:0] held;
    int moved;
    run_mul(next_rand(), next_rand(), "R1 before hold");
    held = product;
    moved = 0;
    for (int i = 0; i < LAT + 3; i++) begin
      mcand = next_rand(); mplr = next_rand();
      @(negedge clk);
      if (product !== held) moved++;
    end
    check_int("R4 product held", moved, 0);
  endtask

  initial begin
    #(1_500_000);
    nfail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    nvec = 0;
    nfail = 0;
    rng = 64'h9E37_79B9_7F4A_7C15;
    t_reset();
    t_zero();
    t_recode();
    t_topbit();
    t_random();
    t_ignore_start();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule